// File: doc/BRIEF.md
# Shared Interrupt Distributor

This block takes a set of shared, level-sensitive interrupt lines and sends each one to the interrupt inputs of up to four processor cores. Every shared line has three settings: a destination mask with one bit per core, a distribution mode and a mask bit. All of them are written through a single command port that carries a command code, a line number and a data word. Nothing reaches any core until a unit-enable command has been issued.

The unit supports two distribution modes. In fixed mode the line is delivered to the lowest-numbered core in its destination mask, because a level interrupt may only have one target. In round-robin mode each new assertion of the line goes to the next core in the mask after the one that took the previous assertion. That core then keeps the line until the line drops. Each core sees one output vector in which bit i carries shared line i. This vector stands for a contiguous block of that core's interrupt numbers.

Top module: `irqDistUnit`

## Requirements
- R1: After reset every core output is 0. No line reaches any core before an enable command (code 1) has been accepted, whatever else has been programmed.
- R2: An enable command (code 1) turns on routing for all lines, and routing stays on until reset. A command is accepted on a clock edge at which cmdValid is 1.
- R3: A set-destination command (code 2) copies cmdData[NUM_CORES-1:0] into the destination mask of the line named by cmdLine. Bit c of the mask selects core c.
- R4: A set-mode command (code 3) looks only at cmdData[1:0]. The value 0 selects round-robin. Any other value selects fixed destination. All other data bits have no effect.
- R5: A set-mask command (code 4) masks the line when cmdData[0] is 1 and unmasks it when cmdData[0] is 0. A masked line drives 0 to every core. Lines come out of reset masked, in fixed mode, with an empty destination mask.
- R6: In fixed mode an active line is delivered only to the lowest-numbered core whose bit is set in the destination mask. The output appears one clock after the line input.
- R7: In round-robin mode each new assertion of a line (0 to 1 while enabled and unmasked) goes to the next core after the one last served, searching upward with wrap-around and skipping cores not in the mask. The first assertion after reset searches from core 0.
- R8: In round-robin mode the core that received an assertion keeps the line until the line deasserts or is masked, even if the destination mask changes in the meantime.
- R9: A line whose destination mask is empty is delivered to no core.
- R10: Shared line i drives only bit i of each core's vector, which is port bit c*NUM_LINES+i for core c. The settings of one line have no effect on any other line.
- R11: A line is delivered to at most one core at a time.
- R12: Command codes 0, 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdCode | input | 3 | Command code: 1 enable, 2 destination, 3 mode, 4 mask |
| cmdLine | input | $clog2(NUM_LINES) | Shared line addressed by the command |
| cmdData | input | 32 | Command data word |
| irqIn | input | NUM_LINES | Shared level interrupt lines |
| coreIrq | output | NUM_CORES*NUM_LINES | Per-core interrupt vectors; core c uses bits [c*NUM_LINES +: NUM_LINES] |

## Verification
A set-mask command can land on the same clock edge at which its line first rises. The bench provokes this by driving both in one cycle to a round-robin line. The edge still sees the old, unmasked setting, so the bench expects the chosen core to hold the line for exactly one cycle and then expects every output to fall to 0. A destination rewrite that lands while a round-robin line is being held is judged the same way: the bench expects the current owner to stay put until the line drops, and the new mask to take effect only at the next assertion.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE   = 3'd0,
    CMD_ENABLE = 3'd1,
    CMD_DEST   = 3'd2,
    CMD_MODE   = 3'd3,
    CMD_MASK   = 3'd4
  } cmdOp_e;

  typedef struct packed {
    logic enWr;
    logic destWr;
    logic modeWr;
    logic maskWr;
  } cmdStrobe_t;

endpackage

// File: rtl/irq_dist_ctrl.sv
module irqDistCtrl
  import irq_dist_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  output cmdStrobe_t strobe,
  output logic       unitEn
);

  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      case (cmdCode)
        CMD_ENABLE: strobe.enWr   = 1'b1;
        CMD_DEST:   strobe.destWr = 1'b1;
        CMD_MODE:   strobe.modeWr = 1'b1;
        CMD_MASK:   strobe.maskWr = 1'b1;
        default:    strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) unitEn <= 1'b0;
    else if (strobe.enWr) unitEn <= 1'b1;
  end

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    unitEn |=> unitEn); // R2

endmodule

// File: rtl/irq_dist_path.sv
module irqDistPath
  import irq_dist_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int NUM_CORES = 4,
  parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  cmdStrobe_t                     strobe,
  input  logic [LINE_W-1:0]              cmdLine,
  input  logic [NUM_CORES-1:0]           destData,
  input  logic [1:0]                     modeData,
  input  logic                           maskData,
  input  logic                           unitEn,
  input  logic [NUM_LINES-1:0]           irqIn,
  output logic [NUM_CORES*NUM_LINES-1:0] coreIrq
);

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic [NUM_CORES-1:0] destMask, owner, ownerNext, fixedSel, rrPick, outQ;
    logic                 rrMode, masked, act, actPrev, rising, pickHit, hit;
    logic [CORE_W-1:0]    lastIdx, pickIdx;

    assign hit = (cmdLine == LINE_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        destMask <= '0;
        rrMode   <= 1'b0;
        masked   <= 1'b1;
      end else if (hit) begin
        if (strobe.destWr) destMask <= destData;
        if (strobe.modeWr) rrMode   <= (modeData == 2'b00);
        if (strobe.maskWr) masked   <= maskData;
      end
    end

    assign act    = irqIn[g] & unitEn & ~masked;
    assign rising = act & ~actPrev;

    always_comb begin
      fixedSel = '0;
      for (int k = NUM_CORES - 1; k >= 0; k--) begin
        if (destMask[k]) begin
          fixedSel    = '0;
          fixedSel[k] = 1'b1;
        end
      end
    end

    always_comb begin
      pickHit = 1'b0;
      pickIdx = lastIdx;
      for (int k = NUM_CORES; k >= 1; k--) begin
        int cand;
        cand = (int'(lastIdx) + k) % NUM_CORES;
        if (destMask[cand]) begin
          pickHit = 1'b1;
          pickIdx = CORE_W'(cand);
        end
      end
      rrPick = '0;
      if (pickHit) rrPick[pickIdx] = 1'b1;
    end

    assign ownerNext = rising ? rrPick : owner;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        actPrev <= 1'b0;
        owner   <= '0;
        lastIdx <= CORE_W'(NUM_CORES - 1);
        outQ    <= '0;
      end else begin
        actPrev <= act;
        owner   <= ownerNext;
        if (rising && pickHit && rrMode) lastIdx <= pickIdx;
        outQ    <= act ? (rrMode ? ownerNext : fixedSel) : '0;
      end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : gCore
      assign coreIrq[c*NUM_LINES + g] = outQ[c];
    end

    AST_ONE_CORE: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(outQ)); // R11
    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      masked |=> (outQ == '0)); // R5
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (!rrMode && destMask == '0) |=> (outQ == '0)); // R9
    AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (rrMode && $stable(rrMode) && act && actPrev) |=> $stable(outQ)); // R8
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !unitEn |=> (coreIrq == '0)); // R1

endmodule

// File: rtl/irq_dist_unit.sv
module irqDistUnit
  import irq_dist_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cmdValid,
  input  logic [2:0]                     cmdCode,
  input  logic [LINE_W-1:0]              cmdLine,
  input  logic [DATA_W-1:0]              cmdData,
  input  logic [NUM_LINES-1:0]           irqIn,
  output logic [NUM_CORES*NUM_LINES-1:0] coreIrq
);

  cmdStrobe_t strobe;
  logic       unitEn;
  logic       unusedData;

  assign unusedData = ^cmdData;

  irqDistCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .strobe   (strobe),
    .unitEn   (unitEn)
  );

  irqDistPath #(
    .NUM_LINES (NUM_LINES),
    .NUM_CORES (NUM_CORES)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdLine  (cmdLine),
    .destData (cmdData[NUM_CORES-1:0]),
    .modeData (cmdData[1:0]),
    .maskData (cmdData[0]),
    .unitEn   (unitEn),
    .irqIn    (irqIn),
    .coreIrq  (coreIrq)
  );

endmodule

// File: tb/tb_irqDistUnit.sv
module tb_irqDistUnit;
  localparam int NL = 8;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdCode = '0;
  logic [2:0]    cmdLine = '0;
  logic [31:0]   cmdData = '0;
  logic [NL-1:0] irqIn = '0;
  logic [NC*NL-1:0] coreIrq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  irqDistUnit dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdLine(cmdLine), .cmdData(cmdData), .irqIn(irqIn), .coreIrq(coreIrq)
  );

  function automatic logic [NC-1:0] col(input int line);
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = coreIrq[c*NL + line];
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic cmd(input logic [2:0] code, input int line, input logic [31:0] data);
    cmdValid = 1'b1; cmdCode = code; cmdLine = 3'(line); cmdData = data;
    step();
    cmdValid = 1'b0; cmdCode = '0; cmdData = '0;
  endtask

  task automatic pulse(input string tag, input int line, input logic [NC-1:0] exp);
    irqIn[line] = 1'b1;
    step();
    check(tag, 32'(col(line)), 32'(exp));
    irqIn[line] = 1'b0;
    step();
  endtask

  task automatic tReset();
    check("R1 reset outputs", coreIrq, '0);
    cmd(3'd4, 0, 32'd0);
    cmd(3'd2, 0, 32'h1);
    cmd(3'd3, 0, 32'h2);
    irqIn[0] = 1'b1;
    step(); step();
    check("R1 no route before enable", 32'(col(0)), 32'h0);
    cmd(3'd0, 0, 32'hFFFF_FFFF);
    cmd(3'd5, 0, 32'hFFFF_FFFF);
    cmd(3'd6, 0, 32'hFFFF_FFFF);
    cmd(3'd7, 0, 32'hFFFF_FFFF);
    step();
    check("R12 unknown codes no enable", 32'(col(0)), 32'h0);
    cmd(3'd1, 0, 32'h0);
    step();
    check("R2 enable routes", 32'(col(0)), 32'h1);
    irqIn[0] = 1'b0;
    step();
    check("R2 line drop", 32'(col(0)), 32'h0);
  endtask

  task automatic tFixed();
    cmd(3'd2, 2, 32'hC);
    cmd(3'd3, 2, 32'h2);
    cmd(3'd4, 2, 32'h0);
    irqIn[2] = 1'b1;
    step();
    check("R6 lowest dest bit", 32'(col(2)), 32'h4);
    check("R10 port bit position", 32'(coreIrq[2*NL+2]), 32'h1);
    check("R10 other lines quiet", coreIrq & ~(32'h1 << (2*NL+2)), 32'h0);
    irqIn[2] = 1'b0;
    step();
    check("R6 follows input", 32'(col(2)), 32'h0);
  endtask

  task automatic tModeBits();
    cmd(3'd2, 3, 32'h6);
    cmd(3'd3, 3, 32'hFFFF_FFFC);
    cmd(3'd4, 3, 32'h0);
    pulse("R4 rr from masked word #1", 3, 4'h2);
    pulse("R4 rr from masked word #2", 3, 4'h4);
    cmd(3'd3, 3, 32'h0000_0011);
    pulse("R4 fixed #1", 3, 4'h2);
    pulse("R4 fixed #2", 3, 4'h2);
  endtask

  task automatic tRoundRobin();
    cmd(3'd2, 4, 32'hB);
    cmd(3'd3, 4, 32'h0);
    cmd(3'd4, 4, 32'h0);
    pulse("R7 rr pick 0", 4, 4'h1);
    pulse("R7 rr pick 1", 4, 4'h2);
    pulse("R7 rr skip to 3", 4, 4'h8);
    pulse("R7 rr wrap to 0", 4, 4'h1);
  endtask

  task automatic tHold();
    cmd(3'd2, 5, 32'h3);
    cmd(3'd3, 5, 32'h0);
    cmd(3'd4, 5, 32'h0);
    irqIn[5] = 1'b1;
    step();
    check("R8 first owner", 32'(col(5)), 32'h1);
    cmd(3'd2, 5, 32'h2);
    step(); step();
    check("R8 owner kept after dest change", 32'(col(5)), 32'h1);
    irqIn[5] = 1'b0;
    step();
    pulse("R3 R8 new dest on next assertion", 5, 4'h2);
  endtask

  task automatic tEmpty();
    cmd(3'd3, 6, 32'h1);
    cmd(3'd4, 6, 32'h0);
    pulse("R9 empty mask fixed", 6, 4'h0);
    cmd(3'd3, 6, 32'h0);
    pulse("R9 empty mask rr", 6, 4'h0);
  endtask

  task automatic tMask();
    cmd(3'd2, 7, 32'h1);
    cmd(3'd3, 7, 32'h3);
    cmd(3'd4, 7, 32'h0);
    irqIn[7] = 1'b1;
    step();
    check("R5 unmasked delivers", 32'(col(7)), 32'h1);
    cmd(3'd4, 7, 32'h1);
    step();
    check("R5 masked quiet", 32'(col(7)), 32'h0);
    cmd(3'd4, 7, 32'h2);
    step();
    check("R5 data bit0 unmasks", 32'(col(7)), 32'h1);
    irqIn[7] = 1'b0;
    step();
  endtask

  task automatic tSameCycle();
    cmd(3'd2, 1, 32'hF);
    cmd(3'd3, 1, 32'h0);
    cmd(3'd4, 1, 32'h0);
    irqIn[1] = 1'b1;
    cmd(3'd4, 1, 32'h1);
    check("R5 R7 mask same edge uses old", 32'(col(1)), 32'h1);
    step();
    check("R5 mask takes hold", 32'(col(1)), 32'h0);
    irqIn[1] = 1'b0;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    tReset();
    tFixed();
    tModeBits();
    tRoundRobin();
    tHold();
    tEmpty();
    tMask();
    tSameCycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule